// File: doc/BRIEF.md
# Affinity-Aware Virtual Processor Dispatcher

This block chooses which virtual processor a physical processor should run next when that physical processor asks for work. It keeps a small table of virtual processor slots. Each slot records whether the processor is ready or blocked and whether it is currently running. It also records the physical processor it last ran on, its home compute block, and an idle-cycle counter that decides whether the slot still has placement affinity.

A physical processor identifier packs three fields. The core number sits in the low `CORE_W` bits, the chip number in the next `CHIP_W` bits, and the compute block in the top `BLK_W` bits. On a request the block sorts every eligible slot into locality tiers relative to the requester. It then picks the best tier and, within that tier, the lowest slot index. The result is returned one cycle later. The chosen slot is marked running and its placement is updated to the requester. Separate strobes handle three events: a slot giving up its time (cede), a slot becoming runnable again on a wake-up or interrupt (wake), and a running slot being handed back to the pool (release).

Top module: `vp_dispatch`

## Requirements
- R1: After reset no slot is ready, so `rsp_vld` is low and a request answers with `rsp_hit` low.
- R2: `rsp_vld` is high in exactly the cycle after a cycle with `req_vld` high, and low otherwise.
- R3: Only a slot that was ready and not running at the request can be returned.
- R4: Tier 0 (`rsp_tier`=0) is a slot with affinity whose last physical processor equals `req_pp`; it wins over all other tiers.
- R5: Tier 1 is a slot with affinity whose last processor shares `req_pp`'s block and chip fields (bits above `CORE_W`).
- R6: Tier 2 is a slot with affinity whose last processor shares `req_pp`'s block field (top `BLK_W` bits).
- R7: Tier 3 is a slot whose home block equals `req_pp`'s block field.
- R8: Tier 4 is a slot without affinity, because it has never run or because it has lost its affinity.
- R9: Among slots in the best non-empty tier, the lowest index is returned.
- R10: The idle counter of a slot is cleared while the slot runs and in the cycle it is dispatched. Otherwise it counts up once per cycle and saturates. A slot has affinity only if it has run at least once and its counter is at most `aff_thr`.
- R11: Cede makes a slot blocked and not running. Wake makes it ready; when both name the same slot in one cycle, wake wins. A blocked slot is never returned.
- R12: A dispatched slot is marked running and records `req_pp` as its last processor. It is not returned again until a release or cede clears the running mark; a dispatch in the same cycle overrides a release or cede.
- R13: When no slot qualifies in any tier, the response has `rsp_hit` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aff_thr | input | CNT_W | Idle cycles a slot may accumulate and still keep affinity |
| cfg_we | input | 1 | Write the home block of slot `cfg_idx` |
| cfg_idx | input | IDX_W | Slot index for the home write |
| cfg_home | input | BLK_W | Home block value |
| wake_vld | input | 1 | Make slot `wake_idx` ready |
| wake_idx | input | IDX_W | Slot to wake |
| cede_vld | input | 1 | Block slot `cede_idx` and clear its running mark |
| cede_idx | input | IDX_W | Slot that cedes |
| rel_vld | input | 1 | Clear the running mark of slot `rel_idx` |
| rel_idx | input | IDX_W | Slot to release |
| req_vld | input | 1 | Physical processor asks for work |
| req_pp | input | BLK_W+CHIP_W+CORE_W | Requester identifier {block, chip, core} |
| rsp_vld | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | A slot was chosen |
| rsp_idx | output | IDX_W | Chosen slot index |
| rsp_tier | output | 3 | Locality tier of the choice (0 to 4) |

## Verification
The bench builds the default set: eight slots, two core bits, one chip bit, two block bits and an 8-bit idle counter. With these values thirty-two physical processors spread over four blocks of two chips. Random requests therefore hit every tier often, and several slots share a home block, which exposes the lowest-index tie-break. Because the threshold is driven randomly between 0 and 40, slots regularly cross it and drop into the no-affinity tier well before the counter saturates.

// File: rtl/vpd_pkg.sv
package vpd_pkg;
   localparam int unsigned N_TIERS = 5;
   localparam int unsigned TIER_W  = 3;

   typedef enum logic [TIER_W-1:0] {
      TIER_CORE = 3'd0,
      TIER_CHIP = 3'd1,
      TIER_BLK  = 3'd2,
      TIER_HOME = 3'd3,
      TIER_FREE = 3'd4
   } tier_e;
endpackage

// File: rtl/vpd_slot.sv
module vpd_slot
   import vpd_pkg::*;
#(
   parameter int unsigned CORE_W = 2,
   parameter int unsigned CHIP_W = 1,
   parameter int unsigned BLK_W  = 2,
   parameter int unsigned CNT_W  = 8,
   localparam int unsigned PID_W = BLK_W + CHIP_W + CORE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PID_W-1:0]   req_pp,
   input  logic [CNT_W-1:0]   aff_thr,
   input  logic               set_home,
   input  logic [BLK_W-1:0]   home_val,
   input  logic               do_wake,
   input  logic               do_cede,
   input  logic               do_rel,
   input  logic               do_take,
   output logic               elig,
   output logic               ready_o,
   output logic [N_TIERS-1:0] hit
);
   logic               ready_q;
   logic               run_q;
   logic               placed_q;
   logic [PID_W-1:0]   last_q;
   logic [BLK_W-1:0]   home_q;
   logic [CNT_W-1:0]   idle_q;
   logic               aff;
   logic               same_pp;
   logic               same_chip;
   logic               same_blk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q  <= 1'b0;
         run_q    <= 1'b0;
         placed_q <= 1'b0;
         last_q   <= '0;
         home_q   <= '0;
         idle_q   <= '0;
      end else begin
         if (set_home) home_q <= home_val;
         if (do_wake)      ready_q <= 1'b1;
         else if (do_cede) ready_q <= 1'b0;
         if (do_take)                run_q <= 1'b1;
         else if (do_cede || do_rel) run_q <= 1'b0;
         if (do_take) begin
            placed_q <= 1'b1;
            last_q   <= req_pp;
         end
         if (run_q || do_take)  idle_q <= '0;
         else if (idle_q != '1) idle_q <= idle_q + 1'b1;
      end
   end

   always_comb begin
      aff       = placed_q && (idle_q <= aff_thr);
      same_pp   = (last_q == req_pp);
      same_chip = (last_q[PID_W-1:CORE_W] == req_pp[PID_W-1:CORE_W]);
      same_blk  = (last_q[PID_W-1 -: BLK_W] == req_pp[PID_W-1 -: BLK_W]);
      elig      = ready_q && !run_q;
      ready_o   = ready_q;
      hit                 = '0;
      hit[int'(TIER_CORE)] = elig && aff && same_pp;
      hit[int'(TIER_CHIP)] = elig && aff && same_chip;
      hit[int'(TIER_BLK)]  = elig && aff && same_blk;
      hit[int'(TIER_HOME)] = elig && (home_q == req_pp[PID_W-1 -: BLK_W]);
      hit[int'(TIER_FREE)] = elig && !aff;
   end
endmodule

// File: rtl/vpd_pick.sv
module vpd_pick
   import vpd_pkg::*;
#(
   parameter int unsigned N_VP  = 8,
   localparam int unsigned IDX_W = (N_VP > 1) ? $clog2(N_VP) : 1
) (
   input  logic [N_TIERS*N_VP-1:0] hits,
   output logic                    found,
   output logic [IDX_W-1:0]        idx,
   output logic [TIER_W-1:0]       tier
);
   logic [N_TIERS-1:0] t_any;
   logic [IDX_W-1:0]   t_idx [N_TIERS];

   for (genvar t = 0; t < N_TIERS; t++) begin : g_tier
      always_comb begin
         t_any[t] = 1'b0;
         t_idx[t] = '0;
         for (int i = N_VP - 1; i >= 0; i--) begin
            if (hits[t*N_VP + i]) begin
               t_any[t] = 1'b1;
               t_idx[t] = IDX_W'(i);
            end
         end
      end
   end

   always_comb begin
      found = 1'b0;
      idx   = '0;
      tier  = '0;
      for (int t = N_TIERS - 1; t >= 0; t--) begin
         if (t_any[t]) begin
            found = 1'b1;
            idx   = t_idx[t];
            tier  = TIER_W'(t);
         end
      end
   end
endmodule

// File: rtl/vp_dispatch.sv
module vp_dispatch
   import vpd_pkg::*;
#(
   parameter int unsigned N_VP   = 8,
   parameter int unsigned CORE_W = 2,
   parameter int unsigned CHIP_W = 1,
   parameter int unsigned BLK_W  = 2,
   parameter int unsigned CNT_W  = 8,
   localparam int unsigned PID_W = BLK_W + CHIP_W + CORE_W,
   localparam int unsigned IDX_W = (N_VP > 1) ? $clog2(N_VP) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  aff_thr,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [BLK_W-1:0]  cfg_home,
   input  logic              wake_vld,
   input  logic [IDX_W-1:0]  wake_idx,
   input  logic              cede_vld,
   input  logic [IDX_W-1:0]  cede_idx,
   input  logic              rel_vld,
   input  logic [IDX_W-1:0]  rel_idx,
   input  logic              req_vld,
   input  logic [PID_W-1:0]  req_pp,
   output logic              rsp_vld,
   output logic              rsp_hit,
   output logic [IDX_W-1:0]  rsp_idx,
   output logic [TIER_W-1:0] rsp_tier
);
   if (N_VP < 2) begin : g_bad_nvp
      $error("vp_dispatch: N_VP must be at least 2");
   end
   if (CORE_W < 1 || CHIP_W < 1 || BLK_W < 1) begin : g_bad_fields
      $error("vp_dispatch: identifier fields need at least one bit each");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("vp_dispatch: CNT_W must be at least 2");
   end

   logic [N_TIERS*N_VP-1:0] hits;
   logic [N_VP-1:0]         elig_vec;
   logic [N_VP-1:0]         ready_vec;
   logic                    pick_found;
   logic [IDX_W-1:0]        pick_idx;
   logic [TIER_W-1:0]       pick_tier;

   for (genvar i = 0; i < N_VP; i++) begin : g_slot
      logic [N_TIERS-1:0] slot_hit;
      logic               take;

      assign take = req_vld && pick_found && (pick_idx == IDX_W'(i));

      vpd_slot #(
         .CORE_W (CORE_W),
         .CHIP_W (CHIP_W),
         .BLK_W  (BLK_W),
         .CNT_W  (CNT_W)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .req_pp   (req_pp),
         .aff_thr  (aff_thr),
         .set_home (cfg_we && (cfg_idx == IDX_W'(i))),
         .home_val (cfg_home),
         .do_wake  (wake_vld && (wake_idx == IDX_W'(i))),
         .do_cede  (cede_vld && (cede_idx == IDX_W'(i))),
         .do_rel   (rel_vld && (rel_idx == IDX_W'(i))),
         .do_take  (take),
         .elig     (elig_vec[i]),
         .ready_o  (ready_vec[i]),
         .hit      (slot_hit)
      );

      for (genvar t = 0; t < N_TIERS; t++) begin : g_map
         assign hits[t*N_VP + i] = slot_hit[t];
      end
   end

   vpd_pick #(
      .N_VP (N_VP)
   ) u_pick (
      .hits  (hits),
      .found (pick_found),
      .idx   (pick_idx),
      .tier  (pick_tier)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_vld  <= 1'b0;
         rsp_hit  <= 1'b0;
         rsp_idx  <= '0;
         rsp_tier <= '0;
      end else begin
         rsp_vld  <= req_vld;
         rsp_hit  <= req_vld && pick_found;
         rsp_idx  <= req_vld ? pick_idx : '0;
         rsp_tier <= req_vld ? pick_tier : '0;
      end
   end
endmodule

// File: rtl/vp_dispatch_chk.sv
module vp_dispatch_chk #(
   parameter int unsigned N_VP  = 8,
   parameter int unsigned IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_vld,
   input logic             wake_vld,
   input logic [IDX_W-1:0] wake_idx,
   input logic             cede_vld,
   input logic [IDX_W-1:0] cede_idx,
   input logic             rsp_vld,
   input logic             rsp_hit,
   input logic [IDX_W-1:0] rsp_idx,
   input logic [N_VP-1:0]  elig_vec,
   input logic [N_VP-1:0]  ready_vec
);
   logic [N_VP-1:0] elig_d;

   always_ff @(posedge clk) begin
      if (!rst_n) elig_d <= '0;
      else        elig_d <= elig_vec;
   end

   // R2
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> rsp_vld);

   // R2
   rsp_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> !rsp_vld);

   // R13
   hit_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_vld |-> !rsp_hit);

   // R3
   pick_was_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && rsp_hit) |-> elig_d[rsp_idx]);

   // R12
   no_repeat_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && rsp_hit && $past(rsp_vld && rsp_hit)) |-> (rsp_idx != $past(rsp_idx)));

   // R11
   cede_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cede_vld && (int'(cede_idx) < N_VP) && !(wake_vld && wake_idx == cede_idx))
         |=> !ready_vec[$past(cede_idx)]);
endmodule

bind vp_dispatch vp_dispatch_chk #(
   .N_VP  (N_VP),
   .IDX_W (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_vld   (req_vld),
   .wake_vld  (wake_vld),
   .wake_idx  (wake_idx),
   .cede_vld  (cede_vld),
   .cede_idx  (cede_idx),
   .rsp_vld   (rsp_vld),
   .rsp_hit   (rsp_hit),
   .rsp_idx   (rsp_idx),
   .elig_vec  (elig_vec),
   .ready_vec (ready_vec)
);

// File: tb/test_vp_dispatch.sv
module test_vp_dispatch;
   localparam int N      = 8;
   localparam int CORE_W = 2;
   localparam int CHIP_W = 1;
   localparam int BLK_W  = 2;
   localparam int CNT_W  = 8;
   localparam int PID_W  = BLK_W + CHIP_W + CORE_W;
   localparam int IDX_W  = 3;
   localparam int CMAX   = (1 << CNT_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [CNT_W-1:0]  aff_thr = '0;
   logic              cfg_we = 1'b0;
   logic [IDX_W-1:0]  cfg_idx = '0;
   logic [BLK_W-1:0]  cfg_home = '0;
   logic              wake_vld = 1'b0;
   logic [IDX_W-1:0]  wake_idx = '0;
   logic              cede_vld = 1'b0;
   logic [IDX_W-1:0]  cede_idx = '0;
   logic              rel_vld = 1'b0;
   logic [IDX_W-1:0]  rel_idx = '0;
   logic              req_vld = 1'b0;
   logic [PID_W-1:0]  req_pp = '0;
   logic              rsp_vld;
   logic              rsp_hit;
   logic [IDX_W-1:0]  rsp_idx;
   logic [2:0]        rsp_tier;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   bit m_ready [N];
   bit m_run   [N];
   bit m_plc   [N];
   int m_last  [N];
   int m_home  [N];
   int m_idle  [N];

   always #10 clk = ~clk;

   vp_dispatch i_vp_dispatch (
      .clk(clk), .rst_n(rst_n), .aff_thr(aff_thr),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_home(cfg_home),
      .wake_vld(wake_vld), .wake_idx(wake_idx),
      .cede_vld(cede_vld), .cede_idx(cede_idx),
      .rel_vld(rel_vld), .rel_idx(rel_idx),
      .req_vld(req_vld), .req_pp(req_pp),
      .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx), .rsp_tier(rsp_tier)
   );

   function automatic bit has_aff(int i);
      return m_plc[i] && (m_idle[i] <= int'(aff_thr));
   endfunction

   function automatic bit in_tier(int i, int t, int pp);
      bit el = m_ready[i] && !m_run[i];
      bit a  = has_aff(i);
      case (t)
         0: return el && a && (m_last[i] == pp);
         1: return el && a && ((m_last[i] >> CORE_W) == (pp >> CORE_W));
         2: return el && a && ((m_last[i] >> (CORE_W+CHIP_W)) == (pp >> (CORE_W+CHIP_W)));
         3: return el && (m_home[i] == (pp >> (CORE_W+CHIP_W)));
         default: return el && !a;
      endcase
   endfunction

   // expected choice from the model (R3..R9, R13)
   task automatic expect_pick(input int pp, output bit hit, output int idx,
                              output int tier, output int ncand);
      hit = 0; idx = 0; tier = 0; ncand = 0;
      for (int t = 0; t < 5 && !hit; t++) begin
         for (int i = 0; i < N; i++) begin
            if (in_tier(i, t, pp)) begin
               if (!hit) begin hit = 1; idx = i; tier = t; end
               ncand++;
            end
         end
      end
   endtask

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
      end
   endtask

   // one clock with the inputs as currently driven
   task automatic step();
      bit e_hit; int e_idx; int e_tier; int e_n;
      string tag;
      bit tk [N];
      expect_pick(int'(req_pp), e_hit, e_idx, e_tier, e_n);
      @(posedge clk);
      #1;
      chk("R2 rsp_vld", int'(rsp_vld), int'(req_vld));
      if (req_vld) begin
         if (!e_hit) tag = "R13 none";
         else begin
            case (e_tier)
               0: tag = "R4 same-core";
               1: tag = "R5 same-chip";
               2: tag = "R6 same-block";
               3: tag = "R7 home-block";
               default: tag = m_plc[e_idx] ? "R8/R10 lost-affinity" : "R8 never-run";
            endcase
            if (e_n > 1) tag = {tag, " R9 tie"};
            tag = {tag, " R3/R12"};
         end
         chk(tag, int'(rsp_hit), int'(e_hit));
         if (e_hit) begin
            chk({tag, " idx"}, int'(rsp_idx), e_idx);
            chk({tag, " tier"}, int'(rsp_tier), e_tier);
         end
      end
      for (int i = 0; i < N; i++) tk[i] = req_vld && e_hit && (e_idx == i);
      for (int i = 0; i < N; i++) begin
         m_idle[i] = (m_run[i] || tk[i]) ? 0 : ((m_idle[i] < CMAX) ? m_idle[i] + 1 : CMAX);
         if (cfg_we && int'(cfg_idx) == i) m_home[i] = int'(cfg_home);
         if (wake_vld && int'(wake_idx) == i) m_ready[i] = 1;
         else if (cede_vld && int'(cede_idx) == i) m_ready[i] = 0;
         if (tk[i]) m_run[i] = 1;
         else if ((cede_vld && int'(cede_idx) == i) || (rel_vld && int'(rel_idx) == i)) m_run[i] = 0;
         if (tk[i]) begin m_plc[i] = 1; m_last[i] = int'(req_pp); end
      end
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      cfg_we = 0; wake_vld = 0; cede_vld = 0; rel_vld = 0; req_vld = 0;
   endtask

   task automatic do_req(input int pp);
      idle_inputs(); req_vld = 1; req_pp = PID_W'(pp); step();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int seed;
      seed = $urandom(32'd4242);
      for (int i = 0; i < N; i++) begin
         m_ready[i] = 0; m_run[i] = 0; m_plc[i] = 0;
         m_last[i] = 0; m_home[i] = 0; m_idle[i] = 0;
      end
      aff_thr = 8'd10;
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      // R1: reset state
      chk("R1 rsp_vld after reset", int'(rsp_vld), 0);
      chk("R1 rsp_hit after reset", int'(rsp_hit), 0);
      do_req(5);
      // homes: slot i -> block i%4
      for (int i = 0; i < N; i++) begin
         idle_inputs(); cfg_we = 1; cfg_idx = IDX_W'(i); cfg_home = BLK_W'(i % 4); step();
      end
      for (int i = 0; i < N; i++) begin
         idle_inputs(); wake_vld = 1; wake_idx = IDX_W'(i); step();
      end
      // block 2, chip 0, core 1 = 17: home tier, slots 2 and 6 tie (R7, R9)
      do_req(17);
      chk("R7/R9 directed pick", int'(rsp_idx), 2);
      do_req(17);
      chk("R12 running slot skipped", int'(rsp_idx), 6);
      idle_inputs(); rel_vld = 1; rel_idx = 3'd2; step();
      do_req(17);
      chk("R4 directed same core", int'(rsp_tier), 0);
      // R11: ceded slot not chosen until woken
      idle_inputs(); cede_vld = 1; cede_idx = 3'd2; step();
      do_req(17);
      chk("R11 ceded slot not picked", int'(rsp_hit && rsp_idx == 3'd2), 0);
      idle_inputs(); wake_vld = 1; wake_idx = 3'd2; step();
      do_req(17);
      chk("R11 woken slot picked", int'(rsp_idx), 2);
      // R10: let slots go idle past a small threshold
      idle_inputs(); aff_thr = 8'd3;
      for (int i = 0; i < N; i++) begin
         idle_inputs(); rel_vld = 1; rel_idx = IDX_W'(i); step();
      end
      repeat (6) begin idle_inputs(); step(); end
      do_req(0);
      // random phase
      for (int c = 0; c < 6000; c++) begin
         idle_inputs();
         if (($urandom % 64) == 0) aff_thr = CNT_W'($urandom % 41);
         if (($urandom % 20) == 0) begin
            cfg_we = 1; cfg_idx = IDX_W'($urandom % N); cfg_home = BLK_W'($urandom);
         end
         if (($urandom % 10) < 3) begin wake_vld = 1; wake_idx = IDX_W'($urandom % N); end
         if (($urandom % 20) < 3) begin cede_vld = 1; cede_idx = IDX_W'($urandom % N); end
         if (($urandom % 5) == 0) begin rel_vld = 1; rel_idx = IDX_W'($urandom % N); end
         if (($urandom % 2) == 0) begin req_vld = 1; req_pp = PID_W'($urandom); end
         step();
      end
      idle_inputs();
      step();
      finish_run();
   end
endmodule